// File: doc/BRIEF.md
# Encoded Reference Clock Divider

This block divides a reference clock down to a phase-comparison rate. A 5-bit select code picks one of 29 division ratios. Each ratio has the form base × 2^k. The base is 1, 5, 6 or 7, chosen by the two upper code bits. The block emits one single-cycle comparison pulse per division period. A test-port output can carry the same pulse when the test-route input is high.

The counter decrements once per reference cycle. It samples the select code only on the edge that ends a period, so a code change never cuts a period short or stretches it. Three codes are reserved. When one of them is sampled, the divider keeps the ratio it was already using. A registered error flag reports that the code being presented is reserved.

Top module: `refdiv_top`

## Requirements
- R1: With sel_i[4:3] = 00, sel_i[2:0] = k (0..7) divides by 2^(k+1): codes 00000 to 00111 give 2, 4, 8, 16, 32, 64, 128 and 256 cycles between pulses.
- R2: With sel_i[4:3] = 01 and k = 1..7, the period is 5·2^(k-1) cycles (5 up to 320).
- R3: With sel_i[4:3] = 10 and k = 1..7, the period is 6·2^(k-1) cycles (6 up to 384).
- R4: With sel_i[4:3] = 11 and k = 1..7, the period is 7·2^(k-1) cycles (7 up to 448).
- R5: The codes 01000, 10000 and 11000 are reserved. If one of them is sampled at a period boundary, the period length stays at the last legal ratio.
- R6: err_o is 1 in the cycle after an edge at which sel_i held a reserved code, and 0 in the cycle after an edge at which sel_i held a legal code.
- R7: fcomp_o is high for exactly one cycle per period. Consecutive pulses are between 2 and 448 cycles apart.
- R8: sel_i is sampled only on the edge that raises fcomp_o. A code change in mid-period leaves the current period's length unchanged, and the new ratio governs the period that starts with the next pulse.
- R9: tport_o equals fcomp_o while tport_en_i is 1, and stays 0 while tport_en_i is 0.
- R10: While rst_ni is low, fcomp_o, tport_o and err_o are 0. The first clock edge after reset is released raises fcomp_o and samples sel_i. If that first code is reserved, the divider falls back to a ratio of 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 5 | Division select code |
| tport_en_i | input | 1 | Routes the comparison pulse to the test port |
| fcomp_o | output | 1 | Comparison pulse, one cycle per period |
| tport_o | output | 1 | Test-port output |
| err_o | output | 1 | Reserved-code flag, registered |

## Verification
A pulse appears on the same rising edge that samples the code. The first period that uses a new code therefore starts at the first pulse after the code is applied and is measured between that pulse and the next. The bench discards the pulse at which the code changes, then counts negative edges between two later pulses. It compares that count with a ratio it computes from the base and shift rules.

The error flag is registered, so it is read at the first negative edge after the edge that sampled the code. The test port has no register, so it is compared with the pulse at the same negative edge. For the mid-period change, the count runs from a known pulse, and the bench expects the old length first and the new one after it.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int SEL_W     = 5;
  localparam int FAM_W     = 2;
  localparam int SHIFT_W   = SEL_W - FAM_W;
  localparam int NUM_FAM   = 1 << FAM_W;
  localparam int MAX_SHIFT = (1 << SHIFT_W) - 1;
  localparam int MAX_BASE  = 7;
  localparam int MAX_RATIO = MAX_BASE << (MAX_SHIFT - 1);
  localparam int CNT_W     = $clog2(MAX_RATIO + 1);
  localparam int FALLBACK  = 2;

  typedef logic [CNT_W-1:0] ratio_t;

  typedef struct packed {
    logic   legal;
    ratio_t ratio;
  } dec_t;

  function automatic int fam_base(input int fam);
    case (fam)
      0: return 1;
      1: return 5;
      2: return 6;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode
  import refdiv_pkg::*;
(
  input  logic [SEL_W-1:0] code_i,
  output dec_t             dec_o
);
  logic [FAM_W-1:0]   fam;
  logic [SHIFT_W-1:0] k;
  logic [SHIFT_W:0]   up_sh;
  logic [SHIFT_W:0]   dn_sh;
  ratio_t             cand [NUM_FAM];

  assign fam   = code_i[SEL_W-1:SHIFT_W];
  assign k     = code_i[SHIFT_W-1:0];
  assign up_sh = {1'b0, k} + 1'b1;
  assign dn_sh = {1'b0, k} - 1'b1;

  for (genvar g = 0; g < NUM_FAM; g++) begin : g_fam
    localparam ratio_t BASE = ratio_t'(fam_base(g));
    if (g == 0) begin : g_pow2
      assign cand[g] = BASE << up_sh;
    end else begin : g_odd
      assign cand[g] = BASE << dn_sh;
    end
  end

  always_comb begin
    dec_o.ratio = cand[fam];
    dec_o.legal = !((fam != '0) && (k == '0));
  end
endmodule

// File: rtl/refdiv_count.sv
module refdiv_count
  import refdiv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_t next_ratio_i,
  output logic   term_o,
  output logic   pulse_o
);
  ratio_t cnt_q;

  assign term_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (term_o) begin
      cnt_q   <= next_ratio_i - 1'b1;
      pulse_o <= 1'b1;
    end else begin
      cnt_q   <= cnt_q - 1'b1;
      pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/refdiv_port.sv
module refdiv_port (
  input  logic en_i,
  input  logic pulse_i,
  output logic port_o
);
  assign port_o = en_i & pulse_i;
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             tport_en_i,
  output logic             fcomp_o,
  output logic             tport_o,
  output logic             err_o
);
  dec_t   dec;
  ratio_t ratio_q;
  ratio_t next_ratio;
  logic   term;

  refdiv_decode u_dec (
    .code_i (sel_i),
    .dec_o  (dec)
  );

  assign next_ratio = dec.legal ? dec.ratio : ratio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= ratio_t'(FALLBACK);
      err_o   <= 1'b0;
    end else begin
      err_o <= !dec.legal;
      if (term) ratio_q <= next_ratio;
    end
  end

  refdiv_count u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .next_ratio_i (next_ratio),
    .term_o       (term),
    .pulse_o      (fcomp_o)
  );

  refdiv_port u_port (
    .en_i    (tport_en_i),
    .pulse_i (fcomp_o),
    .port_o  (tport_o)
  );
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk
  import refdiv_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] sel_i,
  input logic             tport_en_i,
  input logic             fcomp_o,
  input logic             tport_o,
  input logic             err_o
);
  logic [CNT_W:0] gap_q;
  logic           seen_q;
  logic           bad_code;

  assign bad_code = (sel_i[SEL_W-1:SHIFT_W] != '0) && (sel_i[SHIFT_W-1:0] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (fcomp_o) begin
      gap_q  <= 1;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R7: pulse lasts one cycle
  p_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcomp_o |=> !fcomp_o);

  // R7: spacing between pulses stays within the ratio range
  p_gap_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcomp_o && seen_q) |-> (gap_q >= 2 && gap_q <= MAX_RATIO));

  // R6: flag follows the reserved-code test one cycle later
  p_err_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_code |=> err_o);

  p_err_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_code |=> !err_o);

  // R9: test port silent when not routed
  p_port_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tport_en_i |-> !tport_o);

  p_port_copy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tport_en_i |-> (tport_o == fcomp_o));

  // R10: outputs quiet during reset
  always_comb begin
    if (!rst_ni) begin
      a_reset_quiet_r10: assert (!fcomp_o && !tport_o && !err_o);
    end
  end
endmodule

bind refdiv_top refdiv_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .tport_en_i (tport_en_i),
  .fcomp_o    (fcomp_o),
  .tport_o    (tport_o),
  .err_o      (err_o)
);

// File: tb/refdiv_top_test.sv
`timescale 1ns/1ps
module refdiv_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] sel = 5'b00000;
  logic       ten = 1'b0;
  logic       fcomp, tport, err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  refdiv_top uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sel_i      (sel),
    .tport_en_i (ten),
    .fcomp_o    (fcomp),
    .tport_o    (tport),
    .err_o      (err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_ratio(input int fam, input int k);
    int base;
    case (fam)
      0: base = 1;
      1: base = 5;
      2: base = 6;
      default: base = 7;
    endcase
    if (fam == 0) return base << (k + 1);
    return base << (k - 1);
  endfunction

  task automatic wait_pulse();
    do @(negedge clk); while (!fcomp);
  endtask

  task automatic count_period(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fcomp);
  endtask

  task automatic measure(input logic [4:0] code, input int exp, input string tag);
    int n;
    sel = code;
    wait_pulse();
    wait_pulse();
    @(negedge clk);
    check(fcomp == 1'b0, {tag, " width R7"}, fcomp, 0);
    n = 1;
    while (!fcomp) begin
      @(negedge clk);
      n++;
    end
    check(n == exp, tag, n, exp);
  endtask

  task automatic test_reset();
    #1;
    check(!fcomp && !tport && !err, "R10 reset outputs", {fcomp, tport, err}, 0);
    sel = 5'b00010;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(fcomp == 1'b1, "R10 first pulse", fcomp, 1);
    check(err == 1'b0, "R10 err after legal", err, 0);
  endtask

  task automatic test_family(input int fam, input string tag);
    for (int k = 0; k < 8; k++) begin
      if (fam == 0 || k != 0)
        measure(5'((fam << 3) | k), exp_ratio(fam, k), tag);
    end
  endtask

  task automatic test_reserved();
    logic [4:0] legal_c [3];
    logic [4:0] bad_c [3];
    int         exps [3];
    legal_c = '{5'b01001, 5'b10010, 5'b11011};
    bad_c   = '{5'b01000, 5'b10000, 5'b11000};
    exps    = '{5, 12, 28};
    for (int i = 0; i < 3; i++) begin
      measure(legal_c[i], exps[i], "R5 legal before reserved");
      sel = bad_c[i];
      @(negedge clk);
      check(err == 1'b1, "R6 err set", err, 1);
      measure(bad_c[i], exps[i], "R5 reserved keeps ratio");
      sel = legal_c[i];
      @(negedge clk);
      check(err == 1'b0, "R6 err clear", err, 0);
    end
  endtask

  task automatic test_midchange();
    int n;
    measure(5'b11111, 448, "R8 setup long");
    wait_pulse();
    repeat (10) @(negedge clk);
    sel = 5'b00000;
    count_period(n);
    check(n == 438, "R8 current period kept", n + 10, 448);
    count_period(n);
    check(n == 2, "R8 new ratio after boundary", n, 2);
  endtask

  task automatic test_port();
    bit saw = 1'b0;
    ten = 1'b1;
    measure(5'b00011, 16, "R9 period with port");
    check(tport == fcomp, "R9 port follows", tport, fcomp);
    ten = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tport) saw = 1'b1;
    end
    check(saw == 1'b0, "R9 port quiet", saw, 0);
  endtask

  initial begin
    test_reset();
    test_family(0, "R1");
    test_family(1, "R2");
    test_family(2, "R3");
    test_family(3, "R4");
    test_reserved();
    test_midchange();
    test_port();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule